// File: doc/BRIEF.md
# Rotate and Rotate-Through-Carry Unit

This block is a purely combinational rotator for the flag-producing datapath of an integer execution unit. It handles 8, 16 and 32-bit operands and offers four operations. Two are plain circular rotates, left or right. The other two rotate through carry: the incoming carry bit is joined to the operand to form a ring one bit wider. The unit returns the rotated value with a new carry flag and a new overflow flag. No other flag is produced, so the caller keeps sign, zero, parity and adjust flags as they were.

The count input is wider than the rotator needs. Only its five low bits are used. A masked count of zero returns the operand with carry and overflow untouched. Plain rotates reduce the masked count modulo the operand width. Through-carry rotates reduce it modulo the width plus one, so every rotation finishes in a single combinational pass with no iterative stepping.

Top module: `rot_unit`

## Requirements
- R1: Encodings. `opSel` 2'b00 rotates left, 2'b01 rotates right, 2'b10 rotates left through carry, and 2'b11 rotates right through carry. `sizeSel` 2'b00 selects 8 bits and 2'b01 selects 16 bits; both 2'b10 and 2'b11 select 32 bits. Only `countIn[4:0]` is used, and the higher count bits have no effect.
- R2: When the masked count is zero, the result is the operand's selected low bits, `carryOut` equals `carryIn`, and `ovfOut` equals `ovfIn`.
- R3: A plain rotate moves the selected bits circularly by the masked count modulo the operand width, in the selected direction.
- R4: After a nonzero plain rotate, `carryOut` equals the result LSB for a left rotate and the result MSB for a right rotate.
- R5: A through-carry rotate treats {carryIn, operand} as a ring of width+1 bits and turns it by the masked count modulo width+1. The result is the low width bits of the ring, and `carryOut` is the ring bit that lands in the carry position.
- R6: For 16 and 32-bit operands with a masked count of exactly one, overflow is set as follows. Left and left-through-carry give operand MSB XOR operand MSB-1. Right gives result MSB XOR result MSB-1. Right-through-carry gives operand MSB XOR `carryIn`.
- R7: For 16 and 32-bit operands with a masked count of two or more, `ovfOut` is 0.
- R8: For 8-bit operands with any nonzero masked count, overflow comes from the final state. Left gives result bit 7 XOR result bit 0. Left-through-carry gives result bit 7 XOR `carryOut`. Both right rotates give result bit 7 XOR result bit 6.
- R9: Result bits above the selected width are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to rotate; only the selected low bits are used |
| countIn | input | CNT_IN_W (8) | Rotate count; bits [4:0] used |
| sizeSel | input | 2 | Operand width select |
| opSel | input | 2 | Operation select |
| carryIn | input | 1 | Current carry flag |
| ovfIn | input | 1 | Current overflow flag |
| result | output | 32 | Rotated value, zero-extended |
| carryOut | output | 1 | New carry flag |
| ovfOut | output | 1 | New overflow flag |

## Verification
The bench builds the unit with its default parameters: three lanes (8, 16 and 32 bits) and an 8-bit count port. With this configuration it can sweep every count from 0 to 63 against all four size codes and all four operations. Counts of 32 and above therefore exercise the count masking, and the repeated 32-bit code is covered as well. Each count is applied to operand patterns whose top two bits differ within each lane and to every carry and overflow input combination. This reaches the count-one overflow rules, the wrap of the through-carry ring at width+1, and the plain wrap at the operand width.

// File: rtl/rot_pkg.sv
package rot_pkg;
  localparam int LANES  = 3;
  localparam int MAX_W  = 8 << (LANES - 1);
  localparam int MASK_W = $clog2(MAX_W);
  localparam int AMT_W  = MASK_W + 1;

  typedef enum logic [1:0] {
    ROT_LEFT   = 2'b00,
    ROT_RIGHT  = 2'b01,
    RING_LEFT  = 2'b10,
    RING_RIGHT = 2'b11
  } rotOp_e;

  typedef struct packed {
    logic             cntZero;
    logic             cntOne;
    logic             toLeft;
    logic             viaCarry;
    logic [AMT_W-1:0] amt;
    logic [1:0]       laneSel;
  } rotCtrl_t;
endpackage

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import rot_pkg::*;
#(
  parameter int CNT_IN_W = 8
) (
  input  logic [CNT_IN_W-1:0] countIn,
  input  logic [1:0]          opSel,
  input  logic [1:0]          sizeSel,
  output rotCtrl_t            ctrl
);
  logic [MASK_W-1:0] cntM;
  logic [AMT_W-1:0]  cntExt;
  logic [1:0]        laneIdx;
  logic [AMT_W-1:0]  plainAmt [LANES];
  logic [AMT_W-1:0]  ringAmt  [LANES];
  rotOp_e            opDec;

  assign cntM   = countIn[MASK_W-1:0];
  assign cntExt = AMT_W'(cntM);
  assign opDec  = rotOp_e'(opSel);

  generate
    if (CNT_IN_W > MASK_W) begin : g_high
      logic unusedCntHigh;
      assign unusedCntHigh = ^countIn[CNT_IN_W-1:MASK_W];
    end
  endgenerate

  // per-lane modulo with constant divisors
  for (genvar g = 0; g < LANES; g++) begin : g_amt
    assign plainAmt[g] = cntExt % AMT_W'(8 << g);
    assign ringAmt[g]  = cntExt % AMT_W'((8 << g) + 1);
  end

  always_comb begin
    laneIdx = (sizeSel >= 2'(LANES - 1)) ? 2'(LANES - 1) : sizeSel;
    ctrl.cntZero  = (cntM == '0);
    ctrl.cntOne   = (cntM == MASK_W'(1));
    ctrl.toLeft   = (opDec == ROT_LEFT) || (opDec == RING_LEFT);
    ctrl.viaCarry = (opDec == RING_LEFT) || (opDec == RING_RIGHT);
    ctrl.laneSel  = laneIdx;
    ctrl.amt      = ctrl.viaCarry ? ringAmt[laneIdx] : plainAmt[laneIdx];
  end

  always_comb begin
    AST_AMT_BOUND: assert (int'(ctrl.amt) < ((8 << ctrl.laneSel) + int'(ctrl.viaCarry))); // R3
  end
endmodule

// File: rtl/rot_lane.sv
module rot_lane
  import rot_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] opnd,
  input  logic         cin,
  input  rotCtrl_t     ctrl,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  localparam bit NARROW_OVF = (W <= 8);

  logic [2*W-1:0] plainDbl;
  logic [2*W+1:0] ringDbl;

  assign plainDbl = {opnd, opnd};
  assign ringDbl  = {cin, opnd, cin, opnd};

  always_comb begin
    unique case ({ctrl.viaCarry, ctrl.toLeft})
      2'b01: begin
        res  = W'((plainDbl << ctrl.amt) >> W);
        cout = res[0];
      end
      2'b00: begin
        res  = W'(plainDbl >> ctrl.amt);
        cout = res[W-1];
      end
      2'b11: {cout, res} = (W+1)'((ringDbl << ctrl.amt) >> (W + 1));
      default: {cout, res} = (W+1)'(ringDbl >> ctrl.amt);
    endcase
  end

  always_comb begin
    if (NARROW_OVF) begin
      if (ctrl.toLeft) ovf = res[W-1] ^ (ctrl.viaCarry ? cout : res[0]);
      else             ovf = res[W-1] ^ res[W-2];
    end else if (ctrl.cntOne) begin
      if (ctrl.toLeft)        ovf = opnd[W-1] ^ opnd[W-2];
      else if (ctrl.viaCarry) ovf = opnd[W-1] ^ cin;
      else                    ovf = res[W-1] ^ res[W-2];
    end else begin
      ovf = 1'b0;
    end
  end
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
(
  input  logic [MAX_W-1:0] opnd,
  input  logic             carryIn,
  input  logic             ovfIn,
  input  rotCtrl_t         ctrl,
  output logic [MAX_W-1:0] result,
  output logic             carryOut,
  output logic             ovfOut
);
  logic [MAX_W-1:0] laneRes  [LANES];
  logic [MAX_W-1:0] laneMask [LANES];
  logic [MAX_W-1:0] laneTop  [LANES];
  logic             laneC    [LANES];
  logic             laneV    [LANES];
  logic [MAX_W-1:0] selMask;
  logic [MAX_W-1:0] selTop;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = 8 << g;
    logic [LW-1:0] laneOut;
    rot_lane #(.W(LW)) i_lane (
      .opnd (opnd[LW-1:0]),
      .cin  (carryIn),
      .ctrl (ctrl),
      .res  (laneOut),
      .cout (laneC[g]),
      .ovf  (laneV[g])
    );
    assign laneRes[g]  = MAX_W'(laneOut);
    assign laneMask[g] = MAX_W'({LW{1'b1}});
    assign laneTop[g]  = MAX_W'(1) << (LW - 1);
  end

  assign selMask = laneMask[ctrl.laneSel];
  assign selTop  = laneTop[ctrl.laneSel];

  always_comb begin
    if (ctrl.cntZero) begin
      result   = opnd & selMask;
      carryOut = carryIn;
      ovfOut   = ovfIn;
    end else begin
      result   = laneRes[ctrl.laneSel];
      carryOut = laneC[ctrl.laneSel];
      ovfOut   = laneV[ctrl.laneSel];
    end
  end

  always_comb begin
    AST_ZERO_HOLDS: assert (!ctrl.cntZero || (result == (opnd & selMask) && carryOut == carryIn && ovfOut == ovfIn)); // R2
    AST_PLAIN_CARRY: assert (ctrl.cntZero || ctrl.viaCarry || carryOut == (ctrl.toLeft ? result[0] : ((result & selTop) != '0))); // R4
    AST_RING_BITS_KEPT: assert (ctrl.cntZero || !ctrl.viaCarry || $countones({carryOut, result}) == $countones({carryIn, opnd & selMask})); // R5
    AST_WIDE_OVF_CLEAR: assert (ctrl.cntZero || ctrl.cntOne || ctrl.laneSel == 2'd0 || !ovfOut); // R7
    AST_UPPER_ZERO: assert ((result & ~selMask) == '0); // R9
  end
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int CNT_IN_W = 8
) (
  input  logic [MAX_W-1:0]    operand,
  input  logic [CNT_IN_W-1:0] countIn,
  input  logic [1:0]          sizeSel,
  input  logic [1:0]          opSel,
  input  logic                carryIn,
  input  logic                ovfIn,
  output logic [MAX_W-1:0]    result,
  output logic                carryOut,
  output logic                ovfOut
);
  rotCtrl_t ctrl;

  rot_ctrl #(.CNT_IN_W(CNT_IN_W)) i_ctrl (
    .countIn (countIn),
    .opSel   (opSel),
    .sizeSel (sizeSel),
    .ctrl    (ctrl)
  );

  rot_datapath i_datapath (
    .opnd     (operand),
    .carryIn  (carryIn),
    .ovfIn    (ovfIn),
    .ctrl     (ctrl),
    .result   (result),
    .carryOut (carryOut),
    .ovfOut   (ovfOut)
  );
endmodule

// File: tb/test_rot_unit.sv
module test_rot_unit;
  localparam time HALF = 4ns;

  logic        clk = 1'b0;
  logic [31:0] operand = '0;
  logic [7:0]  countIn = '0;
  logic [1:0]  sizeSel = '0;
  logic [1:0]  opSel = '0;
  logic        carryIn = 1'b0;
  logic        ovfIn = 1'b0;
  logic [31:0] result;
  logic        carryOut;
  logic        ovfOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #HALF clk = ~clk;

  rot_unit i_rot_unit (
    .operand (operand), .countIn (countIn), .sizeSel (sizeSel), .opSel (opSel),
    .carryIn (carryIn), .ovfIn (ovfIn),
    .result (result), .carryOut (carryOut), .ovfOut (ovfOut)
  );

  function automatic void refModel(input logic [31:0] op, input logic [7:0] cnt,
                                   input logic [1:0] sz, input logic [1:0] sel,
                                   input logic ci, input logic vi,
                                   output logic [31:0] r, output logic co, output logic vo);
    int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    int c = int'(cnt[4:0]);
    logic [31:0] m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    logic k;
    logic nk;
    r = op & m;
    co = ci;
    vo = vi;
    if (c == 0) return;
    if (!sel[1]) begin
      for (int i = 0; i < c % w; i++) begin
        if (!sel[0]) r = ((r << 1) | (r >> (w - 1))) & m;
        else         r = ((r >> 1) | (r << (w - 1))) & m;
      end
      co = sel[0] ? r[w-1] : r[0];
    end else begin
      k = ci;
      for (int i = 0; i < c; i++) begin
        if (!sel[0]) begin nk = r[w-1]; r = ((r << 1) | 32'(k)) & m; end
        else begin nk = r[0]; r = (r >> 1) | (32'(k) << (w - 1)); end
        k = nk;
      end
      co = k;
    end
    if (w == 8) begin
      case (sel)
        2'b00: vo = r[7] ^ r[0];
        2'b10: vo = r[7] ^ co;
        default: vo = r[7] ^ r[6];
      endcase
    end else if (c == 1) begin
      case (sel)
        2'b01: vo = r[w-1] ^ r[w-2];
        2'b11: vo = op[w-1] ^ ci;
        default: vo = op[w-1] ^ op[w-2];
      endcase
    end else begin
      vo = 1'b0;
    end
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h (op=%0d size=%0d count=%0d operand=%h cin=%b vin=%b)",
               tag, what, act, exp, opSel, sizeSel, countIn, operand, carryIn, ovfIn);
    end
  endtask

  task automatic applyAndCheck(input logic [31:0] op, input logic [7:0] cnt, input logic [1:0] sz,
                               input logic [1:0] sel, input logic ci, input logic vi);
    logic [31:0] er;
    logic ec;
    logic ev;
    int c;
    int w;
    string rTag;
    string cTag;
    string vTag;
    @(posedge clk);
    operand = op; countIn = cnt; sizeSel = sz; opSel = sel; carryIn = ci; ovfIn = vi;
    @(negedge clk);
    refModel(op, cnt, sz, sel, ci, vi, er, ec, ev);
    c = int'(cnt[4:0]);
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    if (c == 0) begin rTag = "R2"; cTag = "R2"; vTag = "R2"; end
    else begin
      rTag = (cnt[7:5] != 0) ? "R1" : (sel[1] ? "R5" : "R3");
      cTag = sel[1] ? "R5" : "R4";
      vTag = (w == 8) ? "R8" : (c == 1) ? "R6" : "R7";
    end
    check(rTag, "result", result, er);
    check(cTag, "carry", 32'(carryOut), 32'(ec));
    check(vTag, "overflow", 32'(ovfOut), 32'(ev));
    check("R9", "upper-bits", result >> w, 32'd0);
  endtask

  initial begin
    logic [31:0] pats [6];
    pats[0] = 32'h0000_0000;
    pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0001;
    pats[3] = 32'h1234_5678;
    pats[4] = 32'h4000_4040;
    pats[5] = 32'hC3A5_5A3C;
    // idle state with all inputs low
    @(negedge clk);
    check("R2", "idle-result", result, 32'd0);
    check("R2", "idle-carry", 32'(carryOut), 32'd0);
    check("R2", "idle-overflow", 32'(ovfOut), 32'd0);
    // hand-worked corners
    applyAndCheck(32'h0000_0081, 8'd1, 2'd0, 2'b00, 1'b0, 1'b0); // R3 ROL byte: 0x03, cf=1, of=1
    check("R3", "rol-byte-literal", result, 32'h0000_0003);
    applyAndCheck(32'h0000_0001, 8'd9, 2'd0, 2'b10, 1'b0, 1'b0); // R5 9 positions on 9-bit ring: unchanged
    check("R5", "rcl-byte-fullring", result, 32'h0000_0001);
    applyAndCheck(32'h0000_00AA, 8'd224, 2'd0, 2'b01, 1'b1, 1'b1); // R1 count 224 masks to 0
    check("R1", "masked-zero-count", {result[30:0], carryOut}, {31'h0000_00AA, 1'b1});
    for (int sel = 0; sel < 4; sel++)
      for (int sz = 0; sz < 4; sz++)
        for (int cnt = 0; cnt < 64; cnt++)
          for (int p = 0; p < 6; p++)
            for (int fl = 0; fl < 4; fl++)
              applyAndCheck(pats[p], 8'(cnt), 2'(sz), 2'(sel), fl[0], fl[1]);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(HALF * 2 * 190000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule